// File: doc/BRIEF.md
# Prefix Active-Part Triplet Encoder

This block rewrites a routing prefix into the compact form that a trie-based address lookup engine stores at its nodes. A prefix of up to 128 bits arrives left-aligned together with its length. The block measures the run of bits at the front that repeat the first bit, and the run at the back that repeats the last bit. Whatever lies between them is the active part. The block returns the front-run length, the active part and its length, the back-run length, and the first and last bit values. The first and last bits, together with the two run lengths, let a trie builder tell apart prefixes whose active parts collide.

Positions are counted from 0 at the most significant bit. The start of the active part is the first set bit when the prefix begins with 0, and the first cleared bit when it begins with 1. The end of the active part is the last set bit when the prefix ends with 0, and the last cleared bit when it ends with 1. A mode input selects 32-bit or 128-bit addresses, which caps the usable prefix length. Prefixes enter through a valid/ready handshake, one per cycle. Each result leaves two clock edges later as a registered word with a single valid pulse. Downstream backpressure stalls the whole pipeline.

Top module: `ptrip_encoder`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0 and in_ready is 1 until a prefix is sent.
- R2: in_prefix is left-aligned, so position 0 is bit 127. Bits at positions at or beyond the effective length have no effect on any output.
- R3: out_x_len equals the number of leading bits equal to the first bit. The active part therefore starts at the first set bit for a prefix starting with 0, and at the first cleared bit for a prefix starting with 1.
- R4: out_z_len equals the number of trailing bits equal to the last bit. The active part therefore ends at the last set bit for a prefix ending with 0, and at the last cleared bit for a prefix ending with 1.
- R5: out_y holds the active part left-aligned, so its first bit is out_y[127]. out_y_len gives its length, and every bit of out_y below the active part is 0.
- R6: out_first and out_last carry the prefix's bits at position 0 and at position length-1. Both are 0 for a zero-length prefix.
- R7: A prefix of effective length 0, or one whose bits are all equal, sets out_degen to 1 with out_x_len equal to the length, out_y_len 0, out_z_len 0 and out_y all zero.
- R8: A prefix made of one run of its first bit followed by one run of the opposite bit is not degenerate. It gives out_y_len 0, with out_x_len and out_z_len equal to the two run lengths.
- R9: The effective length is in_len clamped to 32 when in_v6 is 0, and to 128 when in_v6 is 1.
- R10: A prefix accepted at a clock edge appears on the outputs, with out_valid high, after the next clock edge. out_valid is 0 between those two edges.
- R11: With out_ready held at 1, a new prefix can be accepted at every edge. Each accepted prefix produces exactly one cycle of out_valid, in order.
- R12: While out_valid is 1 and out_ready is 0, in_ready is 0 and all outputs hold their values. in_ready is 0 at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A prefix is offered |
| in_ready | output | 1 | The block takes the offered prefix at this edge |
| in_prefix | input | 128 | Prefix bits, left-aligned |
| in_len | input | 8 | Prefix length in bits |
| in_v6 | input | 1 | 1: 128-bit address mode, 0: 32-bit mode |
| out_valid | output | 1 | Result word is valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_x_len | output | 8 | Length of the leading run |
| out_y | output | 128 | Active part, left-aligned, zero-filled |
| out_y_len | output | 8 | Active part length |
| out_z_len | output | 8 | Length of the trailing run |
| out_first | output | 1 | Bit value at position 0 |
| out_last | output | 1 | Bit value at the last position |
| out_degen | output | 1 | Zero-length or single-valued prefix |

## Verification
The assertions assume that downstream follows the handshake: a result is held only while out_ready is low, and the prefix inputs change only between edges. They also assume that the reset pulse lasts at least one edge before any traffic. The stimulus keeps in_valid and the prefix fields steady from one falling edge to the next, and it drives everything on falling edges. It withdraws a stalled prefix only after an edge at which in_ready was high. The length field is allowed to exceed the mode limit on purpose, so that the clamp is exercised inside the range the properties accept.

// File: rtl/ptrip_pkg.sv
package ptrip_pkg;

   // Which extreme a scanner looks for: first or last, set bit or cleared bit.
   typedef enum logic [1:0] {
      SCAN_MS_SET = 2'd0,
      SCAN_LS_SET = 2'd1,
      SCAN_MS_CLR = 2'd2,
      SCAN_LS_CLR = 2'd3
   } scan_kind_e;

   localparam int PTRIP_V4_BITS = 32;
   localparam int PTRIP_V6_BITS = 128;

endpackage

// File: rtl/ptrip_scan.sv
module ptrip_scan
   import ptrip_pkg::*;
#(
   parameter int         W    = 128,
   parameter int         LW   = 8,
   parameter scan_kind_e KIND = SCAN_MS_SET
) (
   input  logic [W-1:0]  pfx,
   input  logic [LW-1:0] len,
   output logic [LW-1:0] pos,
   output logic          found
);
   localparam bit WANT_CLR = (KIND == SCAN_MS_CLR) || (KIND == SCAN_LS_CLR);
   localparam bit FROM_MSB = (KIND == SCAN_MS_SET) || (KIND == SCAN_MS_CLR);

   if (W < 2 || (1 << LW) <= W) begin : g_bad_width
      $error("ptrip_scan: LW too narrow for W");
   end

   // cand[i] refers to prefix position i, which is bit W-1-i of the vector
   logic [W-1:0] cand;
   for (genvar i = 0; i < W; i++) begin : g_cand
      assign cand[i] = (pfx[W-1-i] ^ WANT_CLR) && (LW'(i) < len);
   end

   if (FROM_MSB) begin : g_first
      always_comb begin
         pos   = '0;
         found = 1'b0;
         for (int i = W - 1; i >= 0; i--) begin
            if (cand[i]) begin
               pos   = LW'(i);
               found = 1'b1;
            end
         end
      end
   end else begin : g_last
      always_comb begin
         pos   = '0;
         found = 1'b0;
         for (int i = 0; i < W; i++) begin
            if (cand[i]) begin
               pos   = LW'(i);
               found = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ptrip_align.sv
module ptrip_align #(
   parameter int W  = 128,
   parameter int LW = 8
) (
   input  logic [W-1:0]  pfx,
   input  logic [LW-1:0] shamt,
   input  logic [LW-1:0] keep,
   output logic [W-1:0]  y
);
   logic [W-1:0] keep_mask;

   always_comb begin
      keep_mask = ~({W{1'b1}} >> keep);
      y         = (pfx << shamt) & keep_mask;
   end

endmodule

// File: rtl/ptrip_encoder.sv
module ptrip_encoder
   import ptrip_pkg::*;
#(
   parameter int  ADDR_W   = PTRIP_V6_BITS,
   parameter int  NARROW_W = PTRIP_V4_BITS,
   localparam int LEN_W    = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_prefix,
   input  logic [LEN_W-1:0]  in_len,
   input  logic              in_v6,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [LEN_W-1:0]  out_x_len,
   output logic [ADDR_W-1:0] out_y,
   output logic [LEN_W-1:0]  out_y_len,
   output logic [LEN_W-1:0]  out_z_len,
   output logic              out_first,
   output logic              out_last,
   output logic              out_degen
);
   localparam logic [LEN_W-1:0] WIDE_LIM   = LEN_W'(ADDR_W);
   localparam logic [LEN_W-1:0] NARROW_LIM = LEN_W'(NARROW_W);

   if (NARROW_W < 1 || NARROW_W > ADDR_W) begin : g_bad_narrow
      $error("ptrip_encoder: NARROW_W must lie in 1..ADDR_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ptrip_encoder: ADDR_W must be at least 2");
   end

   // ---------------- handshake: the whole pipe moves together
   logic advance;
   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;

   // ---------------- stage 0: clamp, mask, pick end bits
   logic [LEN_W-1:0]  lim, eff_len;
   logic [ADDR_W-1:0] len_mask;
   logic              first_in, last_in;

   always_comb begin
      lim      = in_v6 ? WIDE_LIM : NARROW_LIM;
      eff_len  = (in_len > lim) ? lim : in_len;
      len_mask = ~({ADDR_W{1'b1}} >> eff_len);
      first_in = (eff_len != '0) && in_prefix[ADDR_W-1];
      last_in  = 1'b0;
      for (int i = 0; i < ADDR_W; i++) begin
         if (eff_len == LEN_W'(i + 1)) last_in = in_prefix[ADDR_W-1-i];
      end
   end

   logic              s1_valid;
   logic [ADDR_W-1:0] s1_pfx;
   logic [LEN_W-1:0]  s1_len;
   logic              s1_first, s1_last;

   always_ff @(posedge clk) begin
      if (!rst_n)       s1_valid <= 1'b0;
      else if (advance) s1_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (advance && in_valid) begin
         s1_pfx   <= in_prefix & len_mask;
         s1_len   <= eff_len;
         s1_first <= first_in;
         s1_last  <= last_in;
      end
   end

   // ---------------- stage 1: four extreme-bit scanners
   logic [LEN_W-1:0] sc_pos [4];
   logic [3:0]       sc_fnd;

   for (genvar k = 0; k < 4; k++) begin : g_scan
      ptrip_scan #(
         .W    (ADDR_W),
         .LW   (LEN_W),
         .KIND (scan_kind_e'(k))
      ) u_scan (
         .pfx   (s1_pfx),
         .len   (s1_len),
         .pos   (sc_pos[k]),
         .found (sc_fnd[k])
      );
   end

   logic [LEN_W-1:0]  lead_pos, trail_pos;
   logic              lead_fnd, trail_fnd;
   logic [LEN_W-1:0]  nx_x, nx_yl, nx_z;
   logic              nx_degen;
   logic [ADDR_W-1:0] nx_y;

   always_comb begin
      lead_pos  = s1_first ? sc_pos[int'(SCAN_MS_CLR)] : sc_pos[int'(SCAN_MS_SET)];
      lead_fnd  = s1_first ? sc_fnd[int'(SCAN_MS_CLR)] : sc_fnd[int'(SCAN_MS_SET)];
      trail_pos = s1_last  ? sc_pos[int'(SCAN_LS_CLR)] : sc_pos[int'(SCAN_LS_SET)];
      trail_fnd = s1_last  ? sc_fnd[int'(SCAN_LS_CLR)] : sc_fnd[int'(SCAN_LS_SET)];

      nx_degen = 1'b0;
      nx_x     = lead_pos;
      nx_yl    = '0;
      nx_z     = '0;
      if (s1_len == '0 || !lead_fnd || !trail_fnd) begin
         nx_degen = 1'b1;
         nx_x     = s1_len;
      end else if (lead_pos > trail_pos) begin
         // one transition only: the two runs meet, nothing in between
         nx_z = s1_len - lead_pos;
      end else begin
         nx_yl = trail_pos - lead_pos + LEN_W'(1);
         nx_z  = s1_len - trail_pos - LEN_W'(1);
      end
   end

   ptrip_align #(
      .W  (ADDR_W),
      .LW (LEN_W)
   ) u_align (
      .pfx   (s1_pfx),
      .shamt (nx_x),
      .keep  (nx_yl),
      .y     (nx_y)
   );

   // ---------------- stage 2: registered result
   always_ff @(posedge clk) begin
      if (!rst_n)       out_valid <= 1'b0;
      else if (advance) out_valid <= s1_valid;
   end

   always_ff @(posedge clk) begin
      if (advance && s1_valid) begin
         out_x_len <= nx_x;
         out_y     <= nx_y;
         out_y_len <= nx_yl;
         out_z_len <= nx_z;
         out_first <= s1_first;
         out_last  <= s1_last;
         out_degen <= nx_degen;
      end
   end

endmodule

// File: rtl/ptrip_encoder_chk.sv
module ptrip_encoder_chk #(
   parameter int  ADDR_W   = 128,
   parameter int  NARROW_W = 32,
   localparam int LEN_W    = $clog2(ADDR_W + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_v6,
   input logic              out_valid,
   input logic              out_ready,
   input logic [LEN_W-1:0]  out_x_len,
   input logic [ADDR_W-1:0] out_y,
   input logic [LEN_W-1:0]  out_y_len,
   input logic [LEN_W-1:0]  out_z_len,
   input logic              out_first,
   input logic              out_last,
   input logic              out_degen
);
   logic              y_tail_bit;
   logic [ADDR_W-1:0] y_spare;
   int                len_sum;

   always_comb begin
      y_tail_bit = 1'b0;
      for (int i = 0; i < ADDR_W; i++) begin
         if (out_y_len == LEN_W'(i + 1)) y_tail_bit = out_y[ADDR_W-1-i];
      end
      y_spare = out_y & ({ADDR_W{1'b1}} >> out_y_len);
      len_sum = int'(out_x_len) + int'(out_y_len) + int'(out_z_len);
   end

   // R12
   ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (out_valid && !out_ready));

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_y) && $stable(out_x_len)
         && $stable(out_y_len) && $stable(out_z_len) && $stable(out_degen)));

   // R7
   degen_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_degen) |-> (out_y_len == '0 && out_z_len == '0 && out_y == '0));

   // R5
   y_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (y_spare == '0));

   // R3
   y_head_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_y_len != '0) |-> (out_y[ADDR_W-1] != out_first));

   // R4
   y_tail_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_y_len != '0) |-> (y_tail_bit != out_last));

   // R9
   len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (len_sum <= ADDR_W));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

endmodule

bind ptrip_encoder ptrip_encoder_chk #(
   .ADDR_W   (ADDR_W),
   .NARROW_W (NARROW_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_v6     (in_v6),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_x_len (out_x_len),
   .out_y     (out_y),
   .out_y_len (out_y_len),
   .out_z_len (out_z_len),
   .out_first (out_first),
   .out_last  (out_last),
   .out_degen (out_degen)
);

// File: tb/ptrip_encoder_tb.sv
module ptrip_encoder_tb;
   localparam int W  = 128;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid, in_ready, in_v6, out_valid, out_ready;
   logic [W-1:0]  in_prefix, out_y;
   logic [LW-1:0] in_len, out_x_len, out_y_len, out_z_len;
   logic          out_first, out_last, out_degen;

   always #5 clk = ~clk;

   ptrip_encoder u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_prefix(in_prefix), .in_len(in_len), .in_v6(in_v6),
      .out_valid(out_valid), .out_ready(out_ready), .out_x_len(out_x_len),
      .out_y(out_y), .out_y_len(out_y_len), .out_z_len(out_z_len),
      .out_first(out_first), .out_last(out_last), .out_degen(out_degen)
   );

   typedef struct packed {
      logic          degen;
      logic          first;
      logic          last;
      logic [LW-1:0] x;
      logic [LW-1:0] yl;
      logic [LW-1:0] z;
      logic [W-1:0]  y;
   } res_t;

   res_t act;
   assign act = {out_degen, out_first, out_last, out_x_len, out_y_len, out_z_len, out_y};

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // Expected result from the requirements: run lengths counted bit by bit.
   function automatic res_t model(logic [W-1:0] p, int len, bit v6);
      res_t r;
      int   lim, L, x, z;
      bit   f, l;
      r   = '0;
      lim = v6 ? 128 : 32;
      L   = (len > lim) ? lim : len;
      if (L == 0) begin
         r.degen = 1'b1;
         return r;
      end
      f = p[W-1];
      l = p[W-L];
      r.first = f;
      r.last  = l;
      x = 0;
      while (x < L && p[W-1-x] == f) x++;
      if (x == L) begin
         r.degen = 1'b1;
         r.x     = LW'(L);
         return r;
      end
      z = 0;
      while (z < L && p[W-L+z] == l) z++;
      r.x  = LW'(x);
      r.z  = LW'(z);
      r.yl = LW'(L - x - z);
      for (int j = 0; j < L - x - z; j++) r.y[W-1-j] = p[W-1-x-j];
      return r;
   endfunction

   task automatic check_bit(string req, string what, logic a, logic e);
      n_chk++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, a, e);
      end
   endtask

   task automatic check_res(string req, res_t e);
      n_chk++;
      if (out_valid !== 1'b1 || act !== e) begin
         n_fail++;
         $display("FAIL %s result valid=%b actual=%h expected=%h", req, out_valid, act, e);
      end
   endtask

   // One prefix through an idle pipe, checking latency and single pulse.
   task automatic send_one(string req, logic [W-1:0] p, int len, bit v6);
      @(negedge clk);
      in_prefix = p; in_len = LW'(len); in_v6 = v6; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit("R10", "valid before second edge", out_valid, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check_res(req, model(p, len, v6));
      @(posedge clk);
      @(negedge clk);
      check_bit("R11", "single valid pulse", out_valid, 1'b0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
      in_prefix = '0; in_len = '0; in_v6 = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_bit("R1", "out_valid in reset", out_valid, 1'b0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check_bit("R1", "out_valid after reset", out_valid, 1'b0);
      check_bit("R1", "in_ready after reset", in_ready, 1'b1);
   endtask

   task automatic t_four_cases();
      // first/last (0,1): 00000 1010 111
      send_one("R3", {12'b000001010111, 116'b0}, 12, 1'b1);
      // (0,0): 00 1101 0000
      send_one("R4", {10'b0011010000, 118'b0}, 10, 1'b1);
      // (1,0): 111 00101 00
      send_one("R5", {10'b1110010100, 118'b0}, 10, 1'b1);
      // (1,1): 11 0110 111
      send_one("R6", {9'b110110111, 119'b0}, 9, 1'b1);
      send_one("R5", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128, 1'b1);
   endtask

   task automatic t_tail_ignored();
      // same 12-bit prefix with ones past its length: result must match the clean one
      send_one("R2", {12'b000001010111, {116{1'b1}}}, 12, 1'b1);
      send_one("R2", {9'b110110111, 119'h5A5A_A5A5}, 9, 1'b0);
   endtask

   task automatic t_degenerate();
      send_one("R7", {W{1'b1}}, 0, 1'b1);
      send_one("R7", {{20{1'b1}}, 108'h3}, 20, 1'b1);
      send_one("R7", 128'h0, 32, 1'b0);
   endtask

   task automatic t_single_step();
      send_one("R8", {8'b00001111, 120'b0}, 8, 1'b1);
      send_one("R8", {6'b110000, 122'b0}, 6, 1'b0);
   endtask

   task automatic t_clamp();
      // 32-bit mode: length 100 clamps to 32; bits past 32 would change the runs
      send_one("R9", {16'h0000, 16'hFFFF, 4'h0, 92'h0}, 100, 1'b0);
      // 128-bit mode: length 200 clamps to 128
      send_one("R9", {1'b1, 126'b0, 1'b1}, 200, 1'b1);
   endtask

   task automatic t_back_to_back();
      logic [W-1:0] pv [4];
      int           lv [4];
      pv[0] = {12'b000001010111, 116'b0}; lv[0] = 12;
      pv[1] = {8'b00001111, 120'b0};      lv[1] = 8;
      pv[2] = {9'b110110111, 119'b0};     lv[2] = 9;
      pv[3] = {W{1'b0}};                  lv[3] = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i >= 2) check_res("R11", model(pv[i-2], lv[i-2], 1'b1));
         if (i < 4) begin
            in_prefix = pv[i]; in_len = LW'(lv[i]); in_v6 = 1'b1; in_valid = 1'b1;
            check_bit("R11", "ready during stream", in_ready, 1'b1);
         end else begin
            in_valid = 1'b0;
         end
         @(posedge clk);
      end
      @(negedge clk);
      check_bit("R11", "stream ended", out_valid, 1'b0);
   endtask

   task automatic t_backpressure();
      logic [W-1:0] pa, pb;
      res_t         ea;
      pa = {10'b0011010000, 118'b0};
      pb = {10'b1110010100, 118'b0};
      ea = model(pa, 10, 1'b1);
      @(negedge clk);
      out_ready = 1'b0;
      in_prefix = pa; in_len = 8'd10; in_v6 = 1'b1; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_res("R12", ea);
      check_bit("R12", "ready while stalled", in_ready, 1'b0);
      in_prefix = pb; in_len = 8'd10; in_valid = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_res("R12", ea);
      check_bit("R12", "ready still stalled", in_ready, 1'b0);
      out_ready = 1'b1;
      #1;
      check_bit("R12", "ready on release", in_ready, 1'b1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit("R12", "stalled word drained", out_valid, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check_res("R12", model(pb, 10, 1'b1));
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      t_reset();
      t_four_cases();
      t_tail_ignored();
      t_degenerate();
      t_single_step();
      t_clamp();
      t_back_to_back();
      t_backpressure();
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog actual=timeout expected=completion");
         report();
         $finish;
      end
   end

endmodule